// File: doc/BRIEF.md
# Multi-Mode Shift-Register Ring Counter

A synchronous counter whose state lives in one shift register of `WIDTH` bits. Every enabled clock moves the register one place toward bit 0, and a feedback term enters at the top bit. A two-bit mode code picks one of three feedback terms:

- **Ring mode** recirculates bit 0. A single token circulates with a period of `WIDTH`.
- **Twisted mode** feeds back the inverse of bit 0. This gives a sequence of period `2*WIDTH`.
- **Trimmed mode** feeds back the AND of the inverses of bits 0 and 1. This drops the all-ones state and leaves a period of `2*WIDTH-1`, which is 7 states at the default width.

The mode code is captured only while reset is asserted, so the feedback cannot change in the middle of a sequence. The register contents are presented as is on `q`. A decoded position within the current cycle is presented on `idx`.

Each mode self-recovers: any register value outside the selected mode's cycle is replaced by that mode's reset value on the next enabled clock. Typical uses are glitch-free phase generation, one-hot sequencing, and small odd- or even-length dividers. In all of these, a single-event upset must not lock the counter into a parasitic loop.

Top module: `shift_ring_counter`

## Requirements
- R1: With `rst` high at a rising clock edge, `q` becomes a one with only the top bit set (100..0) in ring mode, or all zeros in either twisted mode. `idx` then reads 0.
- R2: Mode code 0 is ring, 1 is twisted, 2 is trimmed, and 3 behaves exactly as ring.
- R3: In ring mode, each enabled clock gives `q <= {q[0], q[WIDTH-1:1]}`. The cycle from reset repeats every `WIDTH` clocks.
- R4: In twisted mode, each enabled clock gives `q <= {~q[0], q[WIDTH-1:1]}`. The cycle repeats every `2*WIDTH` clocks and passes through all ones.
- R5: In trimmed mode, each enabled clock gives `q <= {~q[0] & ~q[1], q[WIDTH-1:1]}`. The cycle repeats every `2*WIDTH-1` clocks. At width 4 the sequence is 0000, 1000, 1100, 1110, 0111, 0011, 0001.
- R6: While `en` is low and `rst` is low, `q` holds its value.
- R7: A change of `mode` while `rst` is low has no effect until the next reset.
- R8: If `q` is not in the selected mode's cycle, the next enabled clock loads that mode's reset value. While `en` is low, the illegal value is held. In ring mode, a legal state has exactly one bit set. In twisted mode, a legal state has at most one change between neighbouring bits. In trimmed mode, a legal state meets the twisted rule and is not all ones.
- R9: `idx` gives the number of enabled clocks since reset, modulo the period, and is combinational from `q`. In ring mode it is the distance of the set bit from the top bit. In twisted modes with `q[0]=0`, it is the count of ones. In twisted modes with `q[0]=1`, it is the period minus the count of ones. For an illegal `q`, it reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also captures `mode` |
| en | input | 1 | Advance enable |
| mode | input | 2 | Feedback select (0 ring, 1 twisted, 2 trimmed, 3 ring) |
| q | output | WIDTH | Shift register contents |
| idx | output | $clog2(2*WIDTH) | Decoded position within the cycle |

## Verification
The bench goes after the wrap points of each mode, where designs typically go wrong:
- **Ring wrap:** a wrong ring feedback loses the token after `WIDTH` clocks.
- **Twisted wrap:** a twisted counter that feeds back bit 0 uninverted never reaches all ones.
- **Trimmed wrap:** a trimmed counter that tests only bit 0 runs eight states instead of seven.

The index is compared on both halves of each twisted cycle. On the falling half, a missing "period minus ones" term makes the count run backwards.

Several cases check state that should not move:
- **Mode code 3:** must fall back to ring.
- **Mode changes mid-run:** must be ignored; a design that sampled `mode` every cycle would jump sequence.
- **Held enable:** must freeze the register.

Finally, an illegal value is planted in the register in each mode. A design without recovery would either hold the value or walk it through a parasitic cycle rather than reloading the reset value.

// File: rtl/shring_pkg.sv
package shring_pkg;

    typedef enum logic [1:0] {
        FB_RING  = 2'd0,
        FB_TWIST = 2'd1,
        FB_TRIM  = 2'd2,
        FB_SPARE = 2'd3
    } fb_mode_e;

    typedef struct packed {
        fb_mode_e mode;
        logic     active;
    } ring_ctrl_t;

    // Spare code folds onto the plain ring.
    function automatic fb_mode_e fold_mode(input logic [1:0] code);
        fb_mode_e m;
        m = fb_mode_e'(code);
        if (m == FB_SPARE) m = FB_RING;
        return m;
    endfunction

    // Twisted variants start from all zeros, the ring from a single token.
    function automatic logic uses_token(input fb_mode_e m);
        return (m == FB_RING) || (m == FB_SPARE);
    endfunction

endpackage

// File: rtl/rsc_feedback.sv
module rsc_feedback
    import shring_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  fb_mode_e         mode,
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] home
);

    logic top_in;

    always_comb begin
        unique case (mode)
            FB_TWIST: top_in = ~cur[0];
            FB_TRIM:  top_in = ~cur[0] & ~cur[1];
            default:  top_in = cur[0];
        endcase
    end

    assign nxt  = {top_in, cur[WIDTH-1:1]};
    assign home = uses_token(mode) ? {1'b1, {(WIDTH-1){1'b0}}} : '0;

endmodule

// File: rtl/rsc_legal.sv
module rsc_legal
    import shring_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  fb_mode_e         mode,
    input  logic [WIDTH-1:0] cur,
    output logic             legal
);

    logic [WIDTH-2:0] seams;
    logic             ring_ok;
    logic             twist_ok;
    logic             all_set;

    genvar g;
    generate
        for (g = 0; g < WIDTH - 1; g++) begin : g_seam
            assign seams[g] = cur[g] ^ cur[g+1];
        end
    endgenerate

    assign ring_ok  = $onehot(cur);
    assign twist_ok = ($countones(seams) <= 1);
    assign all_set  = &cur;

    always_comb begin
        unique case (mode)
            FB_TWIST: legal = twist_ok;
            FB_TRIM:  legal = twist_ok & ~all_set;
            default:  legal = ring_ok;
        endcase
    end

endmodule

// File: rtl/rsc_index.sv
module rsc_index
    import shring_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int IDX_W = $clog2(2 * WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  fb_mode_e         mode,
    input  logic [WIDTH-1:0] cur,
    input  logic             legal,
    output logic [IDX_W-1:0] idx
);

    localparam int CW = IDX_W + 1;

    logic [CW-1:0]    ones;
    logic [CW-1:0]    period;
    logic [CW-1:0]    twist_pos;
    logic [IDX_W-1:0] ring_pos;

    assign ones = CW'($countones(cur));

    always_comb begin
        unique case (mode)
            FB_TWIST: period = CW'(2 * WIDTH);
            FB_TRIM:  period = CW'(2 * WIDTH - 1);
            default:  period = CW'(WIDTH);
        endcase
    end

    assign twist_pos = cur[0] ? (period - ones) : ones;

    always_comb begin
        ring_pos = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (cur[WIDTH-1-i]) ring_pos = i[IDX_W-1:0];
        end
    end

    always_comb begin
        if (!legal)                 idx = '0;
        else if (uses_token(mode))  idx = ring_pos;
        else                        idx = twist_pos[IDX_W-1:0];
    end

    // R9
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |-> ({1'b0, idx} < period));

endmodule

// File: rtl/shift_ring_counter.sv
module shift_ring_counter
    import shring_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int IDX_W = $clog2(2 * WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [1:0]       mode,
    output logic [WIDTH-1:0] q,
    output logic [IDX_W-1:0] idx
);

    ring_ctrl_t       ctrl_q;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] shift_val;
    logic [WIDTH-1:0] home_val;
    logic             legal;
    fb_mode_e         req_mode;
    logic [WIDTH-1:0] load_val;

    assign req_mode = fold_mode(mode);
    assign load_val = uses_token(req_mode) ? {1'b1, {(WIDTH-1){1'b0}}} : '0;

    rsc_feedback #(.WIDTH(WIDTH)) u_fb (
        .mode (ctrl_q.mode),
        .cur  (state_q),
        .nxt  (shift_val),
        .home (home_val)
    );

    rsc_legal #(.WIDTH(WIDTH)) u_legal (
        .mode  (ctrl_q.mode),
        .cur   (state_q),
        .legal (legal)
    );

    rsc_index #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_idx (
        .clk   (clk),
        .rst   (rst),
        .mode  (ctrl_q.mode),
        .cur   (state_q),
        .legal (legal),
        .idx   (idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.mode   <= req_mode;
            ctrl_q.active <= 1'b1;
            state_q       <= load_val;
        end else if (en) begin
            state_q <= legal ? shift_val : home_val;
        end
    end

    assign q = state_q;

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && !en) |=> $stable(q));

    // R3 R4 R5
    shift_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && en && legal) |=> (q[WIDTH-2:0] == $past(q[WIDTH-1:1])));

    // R8
    recover_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && en && !legal) |=> (uses_token(ctrl_q.mode) ? $onehot(q) && q[WIDTH-1] : (q == '0)));

    // R7
    mode_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (ctrl_q.mode == $past(ctrl_q.mode)));

endmodule

// File: tb/tb_shift_ring_counter.sv
module tb_shift_ring_counter;

    localparam int W  = 4;
    localparam int IW = $clog2(2 * W);
    localparam int NV = 18;

    // {mode, enabled steps after reset, expected q, expected idx}
    localparam logic [12:0] VEC [NV] = '{
        {2'd0, 4'd0,  4'b1000, 3'd0},
        {2'd0, 4'd1,  4'b0100, 3'd1},
        {2'd0, 4'd3,  4'b0001, 3'd3},
        {2'd0, 4'd4,  4'b1000, 3'd0},
        {2'd0, 4'd6,  4'b0010, 3'd2},
        {2'd1, 4'd0,  4'b0000, 3'd0},
        {2'd1, 4'd4,  4'b1111, 3'd4},
        {2'd1, 4'd5,  4'b0111, 3'd5},
        {2'd1, 4'd7,  4'b0001, 3'd7},
        {2'd1, 4'd8,  4'b0000, 3'd0},
        {2'd1, 4'd11, 4'b1110, 3'd3},
        {2'd2, 4'd0,  4'b0000, 3'd0},
        {2'd2, 4'd3,  4'b1110, 3'd3},
        {2'd2, 4'd4,  4'b0111, 3'd4},
        {2'd2, 4'd6,  4'b0001, 3'd6},
        {2'd2, 4'd7,  4'b0000, 3'd0},
        {2'd2, 4'd10, 4'b1110, 3'd3},
        {2'd3, 4'd2,  4'b0010, 3'd2}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [W-1:0]  q;
    logic [IW-1:0] idx;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    shift_ring_counter #(.WIDTH(W), .IDX_W(IW)) dut (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .mode (mode),
        .q    (q),
        .idx  (idx)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        rst  = 1'b1;
        en   = 1'b0;
        mode = m;
        tick();
        rst = 1'b0;
    endtask

    task automatic run(input int n);
        en = 1'b1;
        repeat (n) tick();
        en = 1'b0;
    endtask

    initial begin
        #800000;
        failures++;
        checks++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1;
        // R1: reset state in ring mode
        do_reset(2'd0);
        check("R1 ring reset q", 8'(q), 8'b1000);
        check("R1 ring reset idx", 8'(idx), 8'd0);
        do_reset(2'd2);
        check("R1 trimmed reset q", 8'(q), 8'b0000);

        // R2 R3 R4 R5 R9: sequence table
        for (int v = 0; v < NV; v++) begin
            logic [1:0] vm;
            logic [3:0] vs;
            logic [3:0] vq;
            logic [2:0] vi;
            string      tag;
            {vm, vs, vq, vi} = VEC[v];
            tag = (vm == 2'd0) ? "R3" : (vm == 2'd1) ? "R4" : (vm == 2'd2) ? "R5" : "R2";
            do_reset(vm);
            run(int'(vs));
            check({tag, " table q"}, 8'(q), 8'(vq));
            check({"R9 table idx (", tag, ")"}, 8'(idx), 8'(vi));
        end

        // R6: disabled clocks hold the register
        do_reset(2'd1);
        run(3);
        repeat (3) tick();
        check("R6 hold q", 8'(q), 8'b1110);
        check("R6 hold idx", 8'(idx), 8'd3);

        // R7: mode changes outside reset are ignored
        do_reset(2'd1);
        run(2);
        mode = 2'd0;
        run(3);
        check("R7 twisted continues q", 8'(q), 8'b0111);
        check("R7 twisted continues idx", 8'(idx), 8'd5);
        do_reset(2'd0);
        check("R7 new mode at reset", 8'(q), 8'b1000);

        // R8: illegal value in twisted mode held, then recovered
        do_reset(2'd1);
        force dut.state_q = 4'b1010;
        #0;
        release dut.state_q;
        #1;
        check("R9 illegal idx", 8'(idx), 8'd0);
        tick();
        check("R8 illegal held while disabled", 8'(q), 8'b1010);
        run(1);
        check("R8 twisted recovery", 8'(q), 8'b0000);
        run(1);
        check("R8 twisted resumes", 8'(q), 8'b1000);

        // R8: ring with two tokens
        do_reset(2'd0);
        force dut.state_q = 4'b0110;
        #0;
        release dut.state_q;
        #1;
        run(1);
        check("R8 ring recovery q", 8'(q), 8'b1000);
        check("R8 ring recovery idx", 8'(idx), 8'd0);

        // R8: ring with no token
        do_reset(2'd0);
        force dut.state_q = 4'b0000;
        #0;
        release dut.state_q;
        #1;
        run(1);
        check("R8 ring empty recovery", 8'(q), 8'b1000);

        // R8: all ones is illegal only in trimmed mode
        do_reset(2'd2);
        force dut.state_q = 4'b1111;
        #0;
        release dut.state_q;
        #1;
        check("R9 trimmed all-ones idx", 8'(idx), 8'd0);
        run(1);
        check("R8 trimmed recovery", 8'(q), 8'b0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule